// File: doc/BRIEF.md
# Receive Queue with Trigger Level, Idle Timeout and Automatic RTS

This block sits between a serial receiver and a processor read port. Each received byte goes into a small first-in first-out store. The processor takes bytes out from the head. One occupancy count drives every status output:
- full and empty indications;
- a sticky overflow indication;
- a data-ready indication at a programmable fill level;
- an RTS output for hardware flow control, with a selectable pin polarity.

An idle timer counts bit-time ticks while bytes are waiting and nothing moves in or out of the store. It raises a timeout indication once it reaches a programmable compare value, so the processor collects a short tail of data that never reaches the fill level.

A software reset request empties the store. It then holds the store cleared for a fixed number of cycles, reported on a busy output. Each interrupt output is its indication gated by an enable input.

Top module: `rxq_top`

## Requirements
- R1: A byte offered on `rx_valid` is accepted when the store is not full and no software reset is active. A read request is accepted when the store is not empty and no software reset is active. After the clock edge, `occupancy` has risen by one for an accepted byte, fallen by one for an accepted read, and is unchanged when both are accepted.
- R2: `fifo_full` is high exactly when occupancy is 16, and `fifo_empty` exactly when it is 0. When the store is not empty, `rd_data` shows the oldest unread byte, and bytes leave in arrival order.
- R3: A byte offered while the store is full is dropped without changing the contents, and `ovf_flag` is set at the next edge. The flag stays set until a cycle with `ovf_clr` high clears it. If a new overflow happens in that same cycle, the flag stays set.
- R4: `rda_flag` is high exactly when occupancy is greater than `trig_lvl` (a code k asks for k+1 bytes). It therefore drops as soon as reads bring the count back to k or less.
- R5: The idle timer restarts on any of these: an accepted byte or read, an empty store, `idle_en` low, or an active software reset. Otherwise it advances by one on each `bit_tick` until it equals `idle_cmp`. `tout_flag` is set at an edge where `idle_en` is high, the store is not empty, no byte or read is accepted, and the timer equals `idle_cmp`.
- R6: `tout_flag` is cleared by an accepted read or by a software reset. An accepted incoming byte does not clear it.
- R7: RTS is asserted unless `auto_rts_en` is high and occupancy is greater than `rts_lvl` (a code k deasserts at k+1 bytes). It is asserted again once occupancy falls to k or less. With `rts_active_high` = 1 the asserted pin level is 1; with 0 it is 0.
- R8: A cycle with `sw_rst_req` high empties the store at the next edge. `sw_rst_busy` is then high for exactly 3 cycles. Bytes and reads offered while the request or busy is high are ignored. `ovf_flag` is not changed by the software reset.
- R9: `rda_irq`, `tout_irq` and `ovf_irq` each equal their indication ANDed with `ien_rda`, `ien_tout` and `ien_ovf` respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Byte offered by the receiver this cycle |
| rx_data | input | 8 | Offered byte |
| rd_req | input | 1 | Processor read of the head byte |
| rd_data | output | 8 | Oldest unread byte |
| bit_tick | input | 1 | One pulse per serial bit time |
| trig_lvl | input | 4 | Data-ready level code (k means k+1 bytes) |
| rts_lvl | input | 4 | RTS deassert level code (k means k+1 bytes) |
| idle_cmp | input | 8 | Idle timer compare value in ticks |
| idle_en | input | 1 | Idle timer enable |
| auto_rts_en | input | 1 | Automatic RTS control enable |
| rts_active_high | input | 1 | RTS pin polarity, 1 = asserted high |
| ovf_clr | input | 1 | Write-one clear of the overflow indication |
| sw_rst_req | input | 1 | Software reset request pulse |
| ien_rda | input | 1 | Data-ready interrupt enable |
| ien_tout | input | 1 | Timeout interrupt enable |
| ien_ovf | input | 1 | Overflow interrupt enable |
| occupancy | output | 5 | Number of stored bytes, 0 to 16 |
| fifo_full | output | 1 | Store holds 16 bytes |
| fifo_empty | output | 1 | Store holds no bytes |
| ovf_flag | output | 1 | Sticky overflow indication |
| rda_flag | output | 1 | Fill level reached |
| tout_flag | output | 1 | Idle timeout indication |
| rda_irq | output | 1 | Gated data-ready interrupt |
| tout_irq | output | 1 | Gated timeout interrupt |
| ovf_irq | output | 1 | Gated overflow interrupt |
| rts_out | output | 1 | RTS pin |
| sw_rst_busy | output | 1 | Software reset in progress |

## Verification
The bench builds the block with its defaults: 16 entries of 8 bits, an 8-bit idle compare and a 3-cycle software reset. At that depth, filling to full and overrunning takes only a few dozen cycles. Every trigger and RTS level code can be reached, including code 15, which fires only when the store is full.

Small compare values (0, 1 and 5) together with dense tick streams let the timeout fire, clear and re-arm many times per phase. Random phases mix reads, bytes, clears and reset requests at different rates so that simultaneous push, pop and reset cases occur.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned RXQ_DEPTH_DEF   = 16;
  localparam int unsigned RXQ_DW_DEF      = 8;
  localparam int unsigned RXQ_TW_DEF      = 8;
  localparam int unsigned RXQ_RST_CYC_DEF = 3;

  typedef enum logic [1:0] {
    OCC_HOLD = 2'd0,
    OCC_INC  = 2'd1,
    OCC_DEC  = 2'd2
  } occ_op_e;
endpackage

// File: rtl/rxq_swrst.sv
module rxq_swrst #(
  parameter int unsigned CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic busy,
  output logic clr
);
  localparam int unsigned CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (req)             cnt_d = CW'(CYC);
    else if (cnt_q != 0) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != 0);
  assign clr  = req | busy;

  assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> busy);
endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = RXQ_DEPTH_DEF,
  parameter int unsigned DW    = RXQ_DW_DEF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push_req,
  input  logic [DW-1:0]              push_data,
  input  logic                       pop_req,
  output logic [DW-1:0]              head_data,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty,
  output logic                       push_acc,
  output logic                       pop_acc,
  output logic                       ovf_hit
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  occ_op_e       op;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    else                     return p + AW'(1);
  endfunction

  assign full     = (cnt_q == CW'(DEPTH));
  assign empty    = (cnt_q == '0);
  assign push_acc = push_req & ~full & ~clr;
  assign pop_acc  = pop_req & ~empty & ~clr;
  assign ovf_hit  = push_req & full & ~clr;

  always_comb begin
    unique case ({push_acc, pop_acc})
      2'b10:   op = OCC_INC;
      2'b01:   op = OCC_DEC;
      default: op = OCC_HOLD;
    endcase
  end

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (clr) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_acc) wr_d = ptr_next(wr_q);
      if (pop_acc)  rd_d = ptr_next(rd_q);
      case (op)
        OCC_INC: cnt_d = cnt_q + CW'(1);
        OCC_DEC: cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_acc) mem[wr_q] <= push_data;
  end

  assign head_data = mem[rd_q];
  assign count     = cnt_q;

  assert_push_inc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (push_acc && !pop_acc) |=> (count == $past(count) + 1'b1));
  assert_pop_dec_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_acc && !push_acc) |=> (count == $past(count) - 1'b1));
  assert_no_overfill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> (count == $past(count)) || pop_acc || $past(pop_acc) || $past(clr));
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer
  import rxq_pkg::*;
#(
  parameter int unsigned TW = RXQ_TW_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          act,
  input  logic          pop_acc,
  input  logic          tick,
  input  logic          en,
  input  logic          nonempty,
  input  logic [TW-1:0] cmp,
  output logic          tout_flag
);
  logic [TW-1:0] idle_q, idle_d;
  logic          tout_q, tout_d;
  logic          hit;

  assign hit = (idle_q == cmp);

  always_comb begin
    idle_d = idle_q;
    if (clr || act || !en || !nonempty) idle_d = '0;
    else if (tick && !hit)              idle_d = idle_q + TW'(1);
  end

  always_comb begin
    tout_d = tout_q;
    if (clr || pop_acc)                    tout_d = 1'b0;
    else if (en && nonempty && !act && hit) tout_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '0;
      tout_q <= 1'b0;
    end else begin
      idle_q <= idle_d;
      tout_q <= tout_d;
    end
  end

  assign tout_flag = tout_q;

  assert_tout_pop_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop_acc |=> !tout_flag);
  assert_tout_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tout_flag ##1 tout_flag) |-> ($past(en) && $past(nonempty)));
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = RXQ_DEPTH_DEF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(DEPTH+1)-1:0] count,
  input  logic [$clog2(DEPTH)-1:0]   trig_lvl,
  input  logic [$clog2(DEPTH)-1:0]   rts_lvl,
  input  logic                       auto_rts,
  input  logic                       rts_pol,
  input  logic                       ovf_hit,
  input  logic                       ovf_clr,
  input  logic                       tout_flag,
  input  logic                       ien_rda,
  input  logic                       ien_tout,
  input  logic                       ien_ovf,
  output logic                       rda_flag,
  output logic                       ovf_flag,
  output logic                       rts_pin,
  output logic                       rda_irq,
  output logic                       tout_irq,
  output logic                       ovf_irq
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic ovf_q, ovf_d;
  logic rts_assert;

  always_comb begin
    ovf_d = ovf_q;
    if (ovf_hit)      ovf_d = 1'b1;
    else if (ovf_clr) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  assign rda_flag   = (count > CW'(trig_lvl));
  assign rts_assert = ~(auto_rts & (count > CW'(rts_lvl)));
  assign rts_pin    = rts_pol ? rts_assert : ~rts_assert;
  assign ovf_flag   = ovf_q;
  assign rda_irq    = rda_flag & ien_rda;
  assign tout_irq   = tout_flag & ien_tout;
  assign ovf_irq    = ovf_q & ien_ovf;

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
  assert_ovf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hit |=> ovf_flag);
  assert_rts_manual_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_rts |-> (rts_pin == rts_pol));
endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH   = RXQ_DEPTH_DEF,
  parameter int unsigned DW      = RXQ_DW_DEF,
  parameter int unsigned TW      = RXQ_TW_DEF,
  parameter int unsigned RST_CYC = RXQ_RST_CYC_DEF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rx_valid,
  input  logic [DW-1:0]              rx_data,
  input  logic                       rd_req,
  output logic [DW-1:0]              rd_data,
  input  logic                       bit_tick,
  input  logic [$clog2(DEPTH)-1:0]   trig_lvl,
  input  logic [$clog2(DEPTH)-1:0]   rts_lvl,
  input  logic [TW-1:0]              idle_cmp,
  input  logic                       idle_en,
  input  logic                       auto_rts_en,
  input  logic                       rts_active_high,
  input  logic                       ovf_clr,
  input  logic                       sw_rst_req,
  input  logic                       ien_rda,
  input  logic                       ien_tout,
  input  logic                       ien_ovf,
  output logic [$clog2(DEPTH+1)-1:0] occupancy,
  output logic                       fifo_full,
  output logic                       fifo_empty,
  output logic                       ovf_flag,
  output logic                       rda_flag,
  output logic                       tout_flag,
  output logic                       rda_irq,
  output logic                       tout_irq,
  output logic                       ovf_irq,
  output logic                       rts_out,
  output logic                       sw_rst_busy
);
  logic clr, push_acc, pop_acc, ovf_hit;

  rxq_swrst #(.CYC(RST_CYC)) u_swrst (
    .clk(clk), .rst_n(rst_n), .req(sw_rst_req), .busy(sw_rst_busy), .clr(clr)
  );

  rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .push_req(rx_valid), .push_data(rx_data), .pop_req(rd_req),
    .head_data(rd_data), .count(occupancy), .full(fifo_full), .empty(fifo_empty),
    .push_acc(push_acc), .pop_acc(pop_acc), .ovf_hit(ovf_hit)
  );

  rxq_idle_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(clr), .act(push_acc | pop_acc),
    .pop_acc(pop_acc), .tick(bit_tick), .en(idle_en), .nonempty(~fifo_empty),
    .cmp(idle_cmp), .tout_flag(tout_flag)
  );

  rxq_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst_n(rst_n), .count(occupancy), .trig_lvl(trig_lvl),
    .rts_lvl(rts_lvl), .auto_rts(auto_rts_en), .rts_pol(rts_active_high),
    .ovf_hit(ovf_hit), .ovf_clr(ovf_clr), .tout_flag(tout_flag),
    .ien_rda(ien_rda), .ien_tout(ien_tout), .ien_ovf(ien_ovf),
    .rda_flag(rda_flag), .ovf_flag(ovf_flag), .rts_pin(rts_out),
    .rda_irq(rda_irq), .tout_irq(tout_irq), .ovf_irq(ovf_irq)
  );

  assert_reset_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst_busy |-> fifo_empty);
endmodule

// File: tb/rxq_top_bench.sv
`timescale 1ns/1ps
module rxq_top_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic rx_valid, rd_req, bit_tick, idle_en, auto_rts_en, rts_active_high;
  logic ovf_clr, sw_rst_req, ien_rda, ien_tout, ien_ovf;
  logic [7:0] rx_data, rd_data, idle_cmp;
  logic [3:0] trig_lvl, rts_lvl;
  logic [4:0] occupancy;
  logic fifo_full, fifo_empty, ovf_flag, rda_flag, tout_flag;
  logic rda_irq, tout_irq, ovf_irq, rts_out, sw_rst_busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rxq_top u_rxq_top (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rd_req(rd_req), .rd_data(rd_data), .bit_tick(bit_tick),
    .trig_lvl(trig_lvl), .rts_lvl(rts_lvl), .idle_cmp(idle_cmp),
    .idle_en(idle_en), .auto_rts_en(auto_rts_en),
    .rts_active_high(rts_active_high), .ovf_clr(ovf_clr),
    .sw_rst_req(sw_rst_req), .ien_rda(ien_rda), .ien_tout(ien_tout),
    .ien_ovf(ien_ovf), .occupancy(occupancy), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .ovf_flag(ovf_flag), .rda_flag(rda_flag),
    .tout_flag(tout_flag), .rda_irq(rda_irq), .tout_irq(tout_irq),
    .ovf_irq(ovf_irq), .rts_out(rts_out), .sw_rst_busy(sw_rst_busy)
  );

  // behavioural reference
  byte unsigned mq[$];
  bit m_ovf, m_tout;
  int m_idle, m_rc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete(); m_ovf = 0; m_tout = 0; m_idle = 0; m_rc = 0;
    end else begin
      bit full, empty, clr, pa, pp, act;
      full  = (mq.size() == 16);
      empty = (mq.size() == 0);
      clr   = sw_rst_req || (m_rc != 0);
      pa    = rx_valid && !full && !clr;
      pp    = rd_req && !empty && !clr;
      act   = pa || pp;
      if (clr || pp) m_tout = 0;
      else if (idle_en && !empty && !act && m_idle == int'(idle_cmp)) m_tout = 1;
      if (clr || act || !idle_en || empty) m_idle = 0;
      else if (bit_tick && m_idle != int'(idle_cmp)) m_idle = (m_idle + 1) % 256;
      if (rx_valid && full && !clr) m_ovf = 1;
      else if (ovf_clr) m_ovf = 0;
      if (clr) mq.delete();
      else begin
        if (pp) void'(mq.pop_front());
        if (pa) mq.push_back(rx_data);
      end
      if (sw_rst_req) m_rc = 3;
      else if (m_rc != 0) m_rc = m_rc - 1;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    int n;
    bit e_rda, e_rts;
    n = mq.size();
    e_rda = (n > int'(trig_lvl));
    e_rts = (auto_rts_en && n > int'(rts_lvl)) ? !rts_active_high : rts_active_high;
    chk("R1", "occupancy", int'(occupancy), n);
    chk("R2", "full", int'(fifo_full), int'(n == 16));
    chk("R2", "empty", int'(fifo_empty), int'(n == 0));
    if (n != 0) chk("R2", "rd_data", int'(rd_data), int'(mq[0]));
    chk("R3", "ovf_flag", int'(ovf_flag), int'(m_ovf));
    chk("R4", "rda_flag", int'(rda_flag), int'(e_rda));
    chk("R5", "tout_flag", int'(tout_flag), int'(m_tout));
    chk("R7", "rts_out", int'(rts_out), int'(e_rts));
    chk("R8", "sw_rst_busy", int'(sw_rst_busy), int'(m_rc != 0));
    chk("R9", "rda_irq", int'(rda_irq), int'(e_rda && ien_rda));
    chk("R9", "tout_irq", int'(tout_irq), int'(m_tout && ien_tout));
    chk("R9", "ovf_irq", int'(ovf_irq), int'(m_ovf && ien_ovf));
  endtask

  int p_push, p_pop, p_tick, p_oclr, p_req;
  bit once_oclr, once_req;

  task automatic run(int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      compare();
      rx_valid   = ($urandom % 100) < p_push;
      rx_data    = 8'($urandom);
      rd_req     = ($urandom % 100) < p_pop;
      bit_tick   = ($urandom % 100) < p_tick;
      ovf_clr    = once_oclr || (($urandom % 1000) < p_oclr);
      sw_rst_req = once_req || (($urandom % 1000) < p_req);
      once_oclr  = 0;
      once_req   = 0;
    end
  endtask

  task automatic mode(int pu, int po, int ti);
    p_push = pu; p_pop = po; p_tick = ti;
  endtask

  initial begin
    rst_n = 0; rx_valid = 0; rx_data = 0; rd_req = 0; bit_tick = 0;
    trig_lvl = 4'd7; rts_lvl = 4'd11; idle_cmp = 8'd5; idle_en = 0;
    auto_rts_en = 1; rts_active_high = 0; ovf_clr = 0; sw_rst_req = 0;
    ien_rda = 1; ien_tout = 1; ien_ovf = 1;
    p_oclr = 0; p_req = 0; once_oclr = 0; once_req = 0;
    mode(0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    run(2);                       // reset state, all R tags compared
    mode(100, 0, 0); run(22);     // fill past 16: R2 full, R3 overflow, R7 RTS drop
    once_oclr = 1; mode(0, 0, 0); run(3);   // R3 write-one clear
    mode(0, 100, 0); run(20);     // drain: R4 level drop, R7 reassert
    idle_en = 1; idle_cmp = 8'd5;
    mode(100, 0, 0); run(3);
    mode(0, 0, 60); run(40);      // R5 timeout fires
    mode(100, 0, 0); run(1);      // R6 push keeps flag
    mode(0, 0, 60); run(5);
    mode(0, 100, 0); run(1);      // R6 pop clears
    idle_cmp = 8'd0; mode(0, 0, 0); run(10);
    mode(0, 100, 0); run(20);
    mode(100, 0, 0); run(8);      // R8 software reset mid fill
    once_req = 1; run(8);
    idle_en = 0; rts_active_high = 1; auto_rts_en = 0; run(20);
    for (int cfg = 0; cfg < 6; cfg++) begin
      trig_lvl = 4'($urandom); rts_lvl = 4'($urandom);
      idle_cmp = 8'($urandom % 4); idle_en = cfg[0];
      auto_rts_en = (cfg != 2); rts_active_high = cfg[1];
      ien_rda = cfg[0]; ien_tout = !cfg[1]; ien_ovf = cfg[2] || cfg[0];
      p_oclr = 20; p_req = 8;
      mode(40 + cfg * 8, 55 - cfg * 5, 30 + cfg * 10);
      run(1200);
    end
    p_req = 0; mode(0, 0, 0); run(4);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule